// File: doc/BRIEF.md
# Interrupt pending collector

This block gathers the eight interrupt pending bits that a CPU core reports in its cause register. It also turns an active-low nonmaskable interrupt input into single request pulses. The pending field has three parts:

- Two software bits, written by the core through a control-register write.
- Five hardware bits, loaded by an external agent through an interrupt message on the system data bus. A per-bit write enable in the message selects which bits change.
- One timer bit, set when the count register matches the compare register or when a performance counter overflows.

Every pending bit is a register. A change made by an input sampled at a clock edge shows on the read port from that edge onward. The read port presents the field at bits 15:8 of a 16-bit cause word, with bits 7:0 read as zero.

The nonmaskable input is edge-qualified by an arm flag. The first low sample after the input has been seen high produces exactly one request pulse, one cycle wide. A low level present at reset is ignored until the input has first gone high.

Top module: `irq_pending`

## Requirements
- R1: After reset, all eight pending bits read as zero and `nmiReq` is low.
- R2: At an edge where `swWrEn` is high, pending bits 1:0 (cause bits 9:8) take the value of `swWrData`. No other pending bit changes because of this write. While `swWrEn` is low, `swWrData` has no effect.
- R3: At an edge where `busMsgValid` is high, each hardware pending bit i (i = 0..4, pending bit 2+i, cause bit 10+i) whose enable `busData[16+i]` is 1 takes the value of `busData[i]`.
- R4: A hardware pending bit keeps its value when its enable bit is 0 or when `busMsgValid` is low, whatever the data bits hold.
- R5: At an edge where `cntEqCmp` is high, the timer pending bit (pending bit 7, cause bit 15) becomes 1.
- R6: At an edge where any bit of `perfOvf` is high, the timer pending bit becomes 1.
- R7: The timer bit stays set until an edge where `timerClr` is high, which clears it. If a set condition occurs at that same edge, the set wins.
- R8: At the first edge where `nmiInN` is sampled low after it has been sampled high, `nmiReq` goes high for exactly one cycle.
- R9: While `nmiInN` stays low, no further pulse occurs. A new pulse requires at least one high sample followed by a low sample.
- R10: If `nmiInN` is low from reset onward, no pulse occurs until it has been sampled high at least once.
- R11: `causeRd[15:8]` always equals the pending field, and `causeRd[7:0]` always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swWrEn | input | 1 | Control-register write strobe for the software bits |
| swWrData | input | 2 | New values for the software bits |
| busMsgValid | input | 1 | Interrupt message present on the system data bus |
| busData | input | 32 | System data bus; bits 4:0 are values, bits 20:16 are enables |
| cntEqCmp | input | 1 | Count equals compare event |
| perfOvf | input | 2 | Performance counter overflow events |
| timerClr | input | 1 | Clears the timer bit |
| nmiInN | input | 1 | Nonmaskable interrupt input, active low |
| nmiReq | output | 1 | One-cycle nonmaskable interrupt request |
| causeRd | output | 16 | Pending field aligned to cause bits 15:8 |

## Verification
The bus message is driven in several ways, each separating a different fault:

- All five enables set with alternating data, which catches swapped or offset bit lanes.
- A single enable that clears one bit, which shows that the enable gates each lane separately.
- Enables set with the valid strobe low, which catches a missing qualification on valid.

The timer bit is set from the count match and from each overflow lane in turn. It is also driven with set and clear at the same edge, which exposes a reversed priority.

The nonmaskable input is held low through reset, toggled after a single high cycle, and held low for long runs. These patterns separate a level-sensitive implementation from one that re-arms correctly. A long random mix then compares the whole cause word against the bench model on every clock.

// File: rtl/irq_pending_pkg.sv
package irq_pending_pkg;
  localparam int SW_BITS = 2;
  localparam int HW_BITS = 5;
  localparam int PEND_W  = SW_BITS + HW_BITS + 1;

  typedef struct packed {
    logic               swLoad;
    logic [HW_BITS-1:0] hwLoad;
    logic               timerSet;
    logic               timerClr;
    logic               nmiFire;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
  import irq_pending_pkg::*;
#(
  parameter int PERF_CNT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swWrEn,
  input  logic                busMsgValid,
  input  logic [HW_BITS-1:0]  hwEnField,
  input  logic                cntEqCmp,
  input  logic [PERF_CNT-1:0] perfOvf,
  input  logic                timerClrIn,
  input  logic                nmiInN,
  output ctrlStrobes_t        stb
);
  logic nmiArmed;
  logic nmiFire;

  // Arm only after a high sample; reset disarmed so a low level at reset is inert.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiArmed <= 1'b0;
    end else if (nmiInN) begin
      nmiArmed <= 1'b1;
    end else if (nmiFire) begin
      nmiArmed <= 1'b0;
    end
  end

  assign nmiFire = nmiArmed & ~nmiInN;

  for (genvar i = 0; i < HW_BITS; i++) begin : g_hwLoad
    assign stb.hwLoad[i] = busMsgValid & hwEnField[i];
  end

  assign stb.swLoad   = swWrEn;
  assign stb.timerSet = cntEqCmp | (|perfOvf);
  assign stb.timerClr = timerClrIn;
  assign stb.nmiFire  = nmiFire;
endmodule

// File: rtl/irq_pending_dp.sv
module irq_pending_dp
  import irq_pending_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       stb,
  input  logic [SW_BITS-1:0] swData,
  input  logic [HW_BITS-1:0] hwData,
  output logic [PEND_W-1:0]  pend,
  output logic               nmiReq
);
  logic [SW_BITS-1:0] swBits;
  logic [HW_BITS-1:0] hwBits;
  logic               timerBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swBits <= '0;
    end else if (stb.swLoad) begin
      swBits <= swData;
    end
  end

  for (genvar i = 0; i < HW_BITS; i++) begin : g_hwBit
    logic q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= 1'b0;
      end else if (stb.hwLoad[i]) begin
        q <= hwData[i];
      end
    end
    assign hwBits[i] = q;
  end

  // A set event at the same edge as a clear wins, so no event is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerBit <= 1'b0;
    end else if (stb.timerSet) begin
      timerBit <= 1'b1;
    end else if (stb.timerClr) begin
      timerBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiReq <= 1'b0;
    end else begin
      nmiReq <= stb.nmiFire;
    end
  end

  assign pend = {timerBit, hwBits, swBits};
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_pending_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int HW_EN_LSB = 16,
  parameter int PERF_CNT  = 2,
  parameter int CAUSE_W   = 16,
  parameter int PEND_LSB  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swWrEn,
  input  logic [SW_BITS-1:0]  swWrData,
  input  logic                busMsgValid,
  input  logic [BUS_W-1:0]    busData,
  input  logic                cntEqCmp,
  input  logic [PERF_CNT-1:0] perfOvf,
  input  logic                timerClr,
  input  logic                nmiInN,
  output logic                nmiReq,
  output logic [CAUSE_W-1:0]  causeRd
);
  ctrlStrobes_t        stb;
  logic [PEND_W-1:0]   pend;
  logic                busUnused;

  assign busUnused = ^busData;

  irq_pending_ctrl #(.PERF_CNT(PERF_CNT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swWrEn     (swWrEn),
    .busMsgValid(busMsgValid),
    .hwEnField  (busData[HW_EN_LSB +: HW_BITS]),
    .cntEqCmp   (cntEqCmp),
    .perfOvf    (perfOvf),
    .timerClrIn (timerClr),
    .nmiInN     (nmiInN),
    .stb        (stb)
  );

  irq_pending_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .swData (swWrData),
    .hwData (busData[HW_BITS-1:0]),
    .pend   (pend),
    .nmiReq (nmiReq)
  );

  always_comb begin
    causeRd = '0;
    causeRd[PEND_LSB +: PEND_W] = pend;
  end
endmodule

// File: rtl/irq_pending_chk.sv
module irq_pending_chk
  import irq_pending_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int HW_EN_LSB = 16,
  parameter int PERF_CNT  = 2,
  parameter int CAUSE_W   = 16,
  parameter int PEND_LSB  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                swWrEn,
  input logic [SW_BITS-1:0]  swWrData,
  input logic                busMsgValid,
  input logic [BUS_W-1:0]    busData,
  input logic                cntEqCmp,
  input logic [PERF_CNT-1:0] perfOvf,
  input logic                timerClr,
  input logic                nmiInN,
  input logic                nmiReq,
  input logic [CAUSE_W-1:0]  causeRd
);
  localparam int HW_POS    = PEND_LSB + SW_BITS;
  localparam int TIMER_POS = PEND_LSB + PEND_W - 1;

  logic               live;
  logic [HW_BITS-1:0] hwEff;
  logic               setEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  assign hwEff = busMsgValid ? busData[HW_EN_LSB +: HW_BITS] : '0;
  assign setEv = cntEqCmp | (|perfOvf);

  assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(swWrEn) |-> causeRd[PEND_LSB +: SW_BITS] == $past(swWrData));

  assert_hw_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    live |-> ((causeRd[HW_POS +: HW_BITS] ^ $past(busData[HW_BITS-1:0])) & $past(hwEff)) == '0);

  assert_hw_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    live |-> ((causeRd[HW_POS +: HW_BITS] ^ $past(causeRd[HW_POS +: HW_BITS])) & ~$past(hwEff)) == '0);

  assert_timer_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(setEv) |-> causeRd[TIMER_POS]);

  assert_timer_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(timerClr && !setEv) |-> !causeRd[TIMER_POS]);

  assert_nmi_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    live && nmiReq |-> $past(!nmiInN));

  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);

  assert_low_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    causeRd[PEND_LSB-1:0] == '0);
endmodule

bind irq_pending irq_pending_chk #(
  .BUS_W(BUS_W), .HW_EN_LSB(HW_EN_LSB), .PERF_CNT(PERF_CNT),
  .CAUSE_W(CAUSE_W), .PEND_LSB(PEND_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
  .busMsgValid(busMsgValid), .busData(busData), .cntEqCmp(cntEqCmp),
  .perfOvf(perfOvf), .timerClr(timerClr), .nmiInN(nmiInN),
  .nmiReq(nmiReq), .causeRd(causeRd)
);

// File: tb/sim_irq_pending.sv
`timescale 1ns/1ps
module sim_irq_pending;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [1:0]  swWrData = '0;
  logic        busMsgValid = 1'b0;
  logic [31:0] busData = '0;
  logic        cntEqCmp = 1'b0;
  logic [1:0]  perfOvf = '0;
  logic        timerClr = 1'b0;
  logic        nmiInN = 1'b0;
  logic        nmiReq;
  logic [15:0] causeRd;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0] mIp;
  bit mArm;
  bit mNmi;

  always #10 clk = ~clk;

  irq_pending u0 (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .busMsgValid(busMsgValid), .busData(busData), .cntEqCmp(cntEqCmp),
    .perfOvf(perfOvf), .timerClr(timerClr), .nmiInN(nmiInN),
    .nmiReq(nmiReq), .causeRd(causeRd)
  );

  task automatic modelStep();
    if (!rstN) begin
      mIp = '0; mArm = 0; mNmi = 0;
    end else begin
      if (swWrEn) mIp[1:0] = swWrData;
      if (busMsgValid)
        for (int i = 0; i < 5; i++)
          if (busData[16+i]) mIp[2+i] = busData[i];
      if (timerClr) mIp[7] = 1'b0;
      if (cntEqCmp || perfOvf != 0) mIp[7] = 1'b1;
      mNmi = mArm && !nmiInN;
      if (nmiInN) mArm = 1;
      else if (mNmi) mArm = 0;
    end
  endtask

  task automatic cycle(input string tag);
    logic [15:0] expC;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    expC = {mIp, 8'h00};
    checks++;
    if (causeRd !== expC || nmiReq !== mNmi) begin
      fails++;
      $display("FAIL %s: causeRd=%h nmiReq=%b expected causeRd=%h nmiReq=%b",
               tag, causeRd, nmiReq, expC, mNmi);
    end
  endtask

  task automatic idle();
    swWrEn = 0; busMsgValid = 0; cntEqCmp = 0; perfOvf = '0; timerClr = 0;
  endtask

  initial begin
    mIp = '0; mArm = 0; mNmi = 0;
    repeat (3) cycle("R1");
    rstN = 1'b1;
    cycle("R1");
    repeat (3) cycle("R10");          // low since reset: no pulse

    swWrEn = 1; swWrData = 2'b10; cycle("R2");
    swWrData = 2'b01; cycle("R2");
    swWrEn = 0; swWrData = 2'b11; cycle("R2");  // ignored

    busMsgValid = 1; busData = 32'h001F_0015; cycle("R3");
    busData = 32'h0004_0000; cycle("R3");       // clear one lane only
    busData = 32'h0000_001F; cycle("R4");       // no enables
    busMsgValid = 0; busData = 32'h001F_000A; cycle("R4");
    idle(); cycle("R11");

    cntEqCmp = 1; cycle("R5");
    idle(); cycle("R7");
    timerClr = 1; cycle("R7");
    idle(); perfOvf = 2'b01; cycle("R6");
    idle(); timerClr = 1; cycle("R7");
    perfOvf = 2'b10; cycle("R7");               // set wins over clear
    idle(); timerClr = 1; cycle("R7");
    idle();

    nmiInN = 1; cycle("R8");
    nmiInN = 0; cycle("R8");
    cycle("R8");
    repeat (4) cycle("R9");
    nmiInN = 1; cycle("R9");
    nmiInN = 0; cycle("R9");
    cycle("R9");

    for (int n = 0; n < 300; n++) begin
      swWrEn = $urandom_range(0, 3) == 0;
      swWrData = 2'($urandom);
      busMsgValid = $urandom_range(0, 2) == 0;
      busData = $urandom;
      cntEqCmp = $urandom_range(0, 7) == 0;
      perfOvf = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      timerClr = $urandom_range(0, 3) == 0;
      nmiInN = $urandom_range(0, 2) != 0;
      cycle("R11");
    end
    idle();
    cycle("R11");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule